// File: doc/BRIEF.md
# Dual-Channel GPIO Register Block

This block gives software two independent banks of general-purpose pins, each up to 32 bits wide, through a plain 32-bit register port. Each channel holds an output level register and a direction register. A direction bit of 1 makes the pin an input. A direction bit of 0 makes the pin an output that drives the stored level. Input pins pass through a two-stage synchroniser before they are read or watched for changes.

When any input pin of a channel changes, that channel's pending bit is set. Software clears a pending bit by writing a one to it. A single interrupt line combines the pending bits of both channels. Each channel has its own enable bit, and one global enable bit gates the whole line. The channel widths and the reset values of the level and direction registers are parameters.

Top module: `dual_gpio_regs`

## Requirements
- R1: After reset, each channel's level and direction registers hold their parameter reset values. The global enable, the channel enables, the pending bits and `irq` are all zero. With the default parameters every pin is an input and every level bit is 0.
- R2: Software reaches the registers at these fixed byte offsets. Channel 1 level is at 0x000 and channel 1 direction at 0x004. Channel 2 level is at 0x008 and channel 2 direction at 0x00C. The global enable is bit 31 of 0x11C. The pending bits are at 0x120 and the channel enables at 0x128; in both, bit 0 is channel 1 and bit 1 is channel 2. Direction, global enable and channel enable read back the value last written.
- R3: A direction bit of 0 drives the stored level bit on the matching `chN_out` pin and sets the matching `chN_oe` bit to 1. A direction bit of 1 clears that `chN_oe` bit.
- R4: A read of a level register returns the synchronised pin value on input bits and the stored level on output bits. A pin change applied before clock edge k appears in the read value after edge k+1.
- R5: A change on any input pin of a channel sets that channel's pending bit on edge k+2. A change on a pin that is configured as an output sets nothing.
- R6: Writing 1 to a pending bit clears it. Writing 0 to a pending bit leaves it unchanged.
- R7: `irq` is 1 exactly when the global enable is set and at least one pending bit has its channel enable set.
- R8: A read of an offset that is not mapped returns zero. A write to such an offset changes no register.
- R9: Register bits above a channel's width read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, decoded combinationally from `addr` |
| ch1_in | input | W1 | Channel 1 pin inputs |
| ch1_out | output | W1 | Channel 1 driven levels |
| ch1_oe | output | W1 | Channel 1 output enables |
| ch2_in | input | W2 | Channel 2 pin inputs |
| ch2_out | output | W2 | Channel 2 driven levels |
| ch2_oe | output | W2 | Channel 2 output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench configures channel 1 with its upper half as inputs and its lower half as outputs. It then changes the input pins and the output pins separately, which shows whether change detection is masked by direction and whether the read value merges the two sources bit by bit. It samples the read value and the pending bit one cycle before and one cycle at the expected edge, so a synchroniser stage that is missing or extra shows up. It runs a narrow channel 2 with non-default reset values, which exposes width masking and the reset parameters. It steps the global enable, the channel enables and the pending bits through their combinations, which shows which term gates `irq`.

// File: rtl/dual_gpio_regs.sv
module dual_gpio_regs #(
  parameter int W1 = 32,
  parameter int W2 = 32,
  parameter int ADDR_W = 9,
  parameter logic [W1-1:0] LVL1_RST = '0,
  parameter logic [W1-1:0] DIR1_RST = '1,
  parameter logic [W2-1:0] LVL2_RST = '0,
  parameter logic [W2-1:0] DIR2_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [W1-1:0]     ch1_in,
  output logic [W1-1:0]     ch1_out,
  output logic [W1-1:0]     ch1_oe,
  input  logic [W2-1:0]     ch2_in,
  output logic [W2-1:0]     ch2_out,
  output logic [W2-1:0]     ch2_oe,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_LVL1 = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_DIR1 = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_LVL2 = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_DIR2 = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_GEN  = ADDR_W'(12'h11C);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(12'h120);
  localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(12'h128);

  logic [W1-1:0] lvl1, dir1, m1a, m1b, old1;
  logic [W2-1:0] lvl2, dir2, m2a, m2b, old2;
  logic          gen;
  logic [1:0]    ena, pend, moved;

  assign moved   = {|((m2b ^ old2) & dir2), |((m1b ^ old1) & dir1)};
  assign ch1_out = lvl1;
  assign ch1_oe  = ~dir1;
  assign ch2_out = lvl2;
  assign ch2_oe  = ~dir2;
  assign irq     = gen & |(pend & ena);

  wire wr_pend = wr_en && addr == A_PEND;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl1 <= LVL1_RST; dir1 <= DIR1_RST;
      lvl2 <= LVL2_RST; dir2 <= DIR2_RST;
      m1a <= '0; m1b <= '0; old1 <= '0;
      m2a <= '0; m2b <= '0; old2 <= '0;
      gen <= 1'b0; ena <= '0; pend <= '0;
    end else begin
      m1a <= ch1_in; m1b <= m1a; old1 <= m1b;
      m2a <= ch2_in; m2b <= m2a; old2 <= m2b;
      if (wr_en) begin
        case (addr)
          A_LVL1: lvl1 <= wdata[W1-1:0];
          A_DIR1: dir1 <= wdata[W1-1:0];
          A_LVL2: lvl2 <= wdata[W2-1:0];
          A_DIR2: dir2 <= wdata[W2-1:0];
          A_GEN:  gen  <= wdata[31];
          A_ENA:  ena  <= wdata[1:0];
          default: ;
        endcase
      end
      pend <= (pend & ~(wr_pend ? wdata[1:0] : 2'b00)) | moved;
    end
  end

  always_comb begin
    case (addr)
      A_LVL1:  rdata = 32'((m1b & dir1) | (lvl1 & ~dir1));
      A_DIR1:  rdata = 32'(dir1);
      A_LVL2:  rdata = 32'((m2b & dir2) | (lvl2 & ~dir2));
      A_DIR2:  rdata = 32'(dir2);
      A_GEN:   rdata = {gen, 31'd0};
      A_PEND:  rdata = {30'd0, pend};
      A_ENA:   rdata = {30'd0, ena};
      default: rdata = 32'd0;
    endcase
  end

  // R5
  chg_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    moved[0] |=> pend[0]);

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && wdata[0] && !moved[0]) |=> !pend[0]);

  // R6
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[1] && !(wr_pend && wdata[1])) |=> pend[1]);

  // R3
  lvl_drives_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_LVL1) |=> ch1_out == $past(wdata[W1-1:0]));

  // R7
  gen_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_GEN && !wdata[31]) |=> !irq);
endmodule

// File: tb/dual_gpio_regs_bench.sv
module dual_gpio_regs_bench;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [31:0] ch1_in = '0, ch1_out, ch1_oe;
  logic [7:0]  ch2_in = '0, ch2_out, ch2_oe;
  logic        irq;
  int checks = 0, fails = 0;

  always #5ns clk = ~clk;

  dual_gpio_regs #(.W1(32), .W2(8), .LVL2_RST(8'hA5), .DIR2_RST(8'h0F)) u_dual_gpio_regs (
    .clk, .rst_n, .wr_en, .addr, .wdata, .rdata,
    .ch1_in, .ch1_out, .ch1_oe, .ch2_in, .ch2_out, .ch2_oe, .irq);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    addr = a; #1ns; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(9'h000, v); check("R1 lvl1", v, 32'h0);
    rd(9'h004, v); check("R1 dir1", v, 32'hFFFF_FFFF);
    rd(9'h008, v); check("R1 lvl2", v, 32'h0000_00A0);
    rd(9'h00C, v); check("R1 dir2", v, 32'h0000_000F);
    rd(9'h11C, v); check("R1 gen", v, 32'h0);
    rd(9'h120, v); check("R1 pend", v, 32'h0);
    rd(9'h128, v); check("R1 ena", v, 32'h0);
    check("R1 irq", 32'(irq), 0);
    check("R1 oe1", ch1_oe, 32'h0);
    check("R3 oe2", 32'(ch2_oe), 32'hF0);
    check("R3 out2", 32'(ch2_out), 32'hA5);
  endtask

  task automatic t_outputs;
    logic [31:0] v;
    wr(9'h004, 32'hFFFF_0000);
    wr(9'h000, 32'h1234_ABCD);
    check("R3 out1", ch1_out, 32'h1234_ABCD);
    check("R3 oe1", ch1_oe, 32'h0000_FFFF);
    rd(9'h004, v); check("R2 dir1 readback", v, 32'hFFFF_0000);
    rd(9'h000, v); check("R4 merged read", v, 32'h0000_ABCD);
  endtask

  task automatic t_input_change;
    logic [31:0] v;
    @(negedge clk); ch1_in = 32'h5A5A_0000;
    @(negedge clk); rd(9'h000, v); check("R4 one edge", v, 32'h0000_ABCD);
    @(negedge clk); rd(9'h000, v); check("R4 two edges", v, 32'h5A5A_ABCD);
    rd(9'h120, v); check("R5 not yet", v, 32'h0);
    @(negedge clk); rd(9'h120, v); check("R5 pend ch1", v, 32'h1);
    check("R7 no enables", 32'(irq), 0);
    wr(9'h128, 32'h1);
    check("R7 gen off", 32'(irq), 0);
    wr(9'h11C, 32'h8000_0000);
    rd(9'h11C, v); check("R2 gen readback", v, 32'h8000_0000);
    check("R7 irq on", 32'(irq), 1);
    wr(9'h120, 32'h2);
    rd(9'h120, v); check("R6 zero keeps", v, 32'h1);
    wr(9'h120, 32'h1);
    rd(9'h120, v); check("R6 one clears", v, 32'h0);
    check("R7 irq off", 32'(irq), 0);
  endtask

  task automatic t_output_pins_ignored;
    logic [31:0] v;
    @(negedge clk); ch1_in = 32'h5A5A_FFFF;
    repeat (4) @(negedge clk);
    rd(9'h120, v); check("R5 output pins ignored", v, 32'h0);
    rd(9'h000, v); check("R4 output bits kept", v, 32'h5A5A_ABCD);
  endtask

  task automatic t_chan2;
    logic [31:0] v;
    @(negedge clk); ch2_in = 8'h01;
    repeat (3) @(negedge clk);
    rd(9'h120, v); check("R5 pend ch2", v, 32'h2);
    check("R7 ch2 not enabled", 32'(irq), 0);
    rd(9'h008, v); check("R9 lvl2 width", v, 32'h0000_00A1);
    wr(9'h128, 32'h3);
    rd(9'h128, v); check("R2 ena readback", v, 32'h3);
    check("R7 ch2 enabled", 32'(irq), 1);
    wr(9'h00C, 32'hFFFF_FFFF);
    rd(9'h00C, v); check("R9 dir2 width", v, 32'h0000_00FF);
    wr(9'h11C, 32'h0);
    check("R7 gen cleared", 32'(irq), 0);
    wr(9'h120, 32'h3);
    rd(9'h120, v); check("R6 clear ch2", v, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(9'h010, v); check("R8 read 0x010", v, 32'h0);
    rd(9'h124, v); check("R8 read 0x124", v, 32'h0);
    rd(9'h1FC, v); check("R8 read 0x1FC", v, 32'h0);
    wr(9'h010, 32'hFFFF_FFFF);
    wr(9'h124, 32'hFFFF_FFFF);
    rd(9'h000, v); check("R8 lvl1 untouched", v, 32'h5A5A_ABCD);
    rd(9'h004, v); check("R8 dir1 untouched", v, 32'hFFFF_0000);
    rd(9'h128, v); check("R8 ena untouched", v, 32'h3);
    rd(9'h11C, v); check("R8 gen untouched", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_outputs();
    t_input_change();
    t_output_pins_ignored();
    t_chan2();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1ms;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule